// File: doc/BRIEF.md
# Multi-Prefix Opcode Fetch Sequencer

This block sits at the front of an 8-bit processor's decode path. It reads instruction bytes one at a time over a byte-wide request/acknowledge memory port, and it recognises the four escape bytes that can come before an opcode. It folds up to two of them into a 4-bit prefix set. It then hands the final opcode byte and that set to a downstream decoder as a single-cycle strobe. Prefix combinations that the decoder has no table for are marked with a single-cycle invalid flag, and the decoder treats them as a no-operation.

Once an opcode has been presented, the sequencer waits for the decoder. The decoder asks for the next instruction, for a 16-bit little-endian immediate, or tells the sequencer that a halt was executed. A halt latches, and no further bytes are fetched until reset. The program counter steps by one for every byte the memory acknowledges, and it drives the memory address directly.

Top module: `opfetch_seq`

## Requirements
- R1: After reset, pc is 0, op_valid, op_invalid, imm_valid and halted are low, and mem_req is high, so the first byte is requested from address 0.
- R2: A first byte that is not an escape byte is presented as the opcode with op_class 0. op_valid is high for exactly one cycle, in the cycle after the acknowledge.
- R3: Escape bytes map onto op_class bits: 0xED sets bit 0 (value 1), 0xCB sets bit 1 (value 2), 0xDD sets bit 2 (value 4) and 0xFD sets bit 3 (value 8). An escape byte is never itself presented as the opcode when it opens an instruction.
- R4: After a first escape byte of 0xED or 0xCB, the next byte is always the opcode, even when it is an escape value.
- R5: After a first escape byte of 0xDD or 0xFD, an escape byte in second place is ORed into the set, and the third byte is the opcode whatever its value. A non-escape second byte is the opcode.
- R6: op_invalid is high together with op_valid exactly when op_class is not one of 0, 1, 2, 4, 6, 8 or 10.
- R7: pc rises by one on each cycle where mem_req and mem_ack are both high. It holds in every other cycle, including cycles where mem_ack arrives while no request is open.
- R8: mem_addr always equals pc.
- R9: After op_valid, mem_req stays low until next_req, imm_req or halt_req is seen.
- R10: An immediate request fetches two bytes from consecutive addresses, low byte first. The sequencer then pulses imm_valid for one cycle with imm_data = {second byte, first byte}.
- R11: halt_req while waiting sets halted, and halted stays set until reset. While halted, mem_req stays low and pc stays unchanged.
- R12: While waiting, halt_req takes priority over imm_req, and imm_req takes priority over next_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_req | output | 1 | A byte read is open |
| mem_addr | output | 16 | Read address, equal to pc |
| mem_ack | input | 1 | Read data valid this cycle |
| mem_rdata | input | 8 | Read data byte |
| next_req | input | 1 | Decoder asks for the next instruction |
| imm_req | input | 1 | Decoder asks for a 16-bit immediate |
| halt_req | input | 1 | Decoder reports a halt |
| op_valid | output | 1 | Opcode and class strobe |
| op_class | output | 4 | Accumulated prefix set |
| op_byte | output | 8 | Final opcode byte |
| op_invalid | output | 1 | Prefix set has no dispatch class |
| imm_valid | output | 1 | Immediate strobe |
| imm_data | output | 16 | Assembled immediate |
| halted | output | 1 | Halt latch |
| pc | output | 16 | Program counter |

## Verification
The assertions assume the memory raises mem_ack only for a single cycle per byte. They also assume the decoder raises next_req, imm_req or halt_req only while the sequencer is idle after a strobe. An acknowledge with no open request is allowed, and the checker expects it to be ignored. The stimulus drives every acknowledge as a one-cycle pulse with a varying number of wait cycles before it. It asserts the decoder requests only after checking that mem_req has dropped, apart from the deliberate stray acknowledges used to test R7 and R11.

// File: rtl/opf_pkg.sv
package opf_pkg;

  localparam logic [7:0] ESC_EXT = 8'hED;
  localparam logic [7:0] ESC_BIT = 8'hCB;
  localparam logic [7:0] ESC_IXA = 8'hDD;
  localparam logic [7:0] ESC_IXB = 8'hFD;

  localparam int PFX_W = 4;
  typedef logic [PFX_W-1:0] pfx_set_t;

  localparam pfx_set_t PS_NONE = 4'b0000;
  localparam pfx_set_t PS_EXT  = 4'b0001;
  localparam pfx_set_t PS_BIT  = 4'b0010;
  localparam pfx_set_t PS_IXA  = 4'b0100;
  localparam pfx_set_t PS_IXB  = 4'b1000;

  typedef enum logic [2:0] {
    ST_OP1,
    ST_OP2,
    ST_OP3,
    ST_IMM_LO,
    ST_IMM_HI,
    ST_IDLE,
    ST_HALT
  } seq_state_t;

  function automatic pfx_set_t byte_to_pfx(input logic [7:0] b);
    case (b)
      ESC_EXT: byte_to_pfx = PS_EXT;
      ESC_BIT: byte_to_pfx = PS_BIT;
      ESC_IXA: byte_to_pfx = PS_IXA;
      ESC_IXB: byte_to_pfx = PS_IXB;
      default: byte_to_pfx = PS_NONE;
    endcase
  endfunction

  function automatic logic can_chain(input pfx_set_t p);
    can_chain = (p == PS_IXA) || (p == PS_IXB);
  endfunction

endpackage

// File: rtl/opf_pfx_dec.sv
module opf_pfx_dec
  import opf_pkg::*;
#(
  parameter int NCLS = 1 << PFX_W
) (
  input  logic [7:0] byte_i,
  input  pfx_set_t   cand_i,
  output pfx_set_t   pfx_o,
  output logic       legal_o
);

  logic [NCLS-1:0] legal_mask;

  // Legal sets: the extended escape alone, or any set without it that
  // does not hold both index escapes.
  for (genvar g = 0; g < NCLS; g++) begin : g_cls
    localparam logic [PFX_W-1:0] GV = PFX_W'(g);
    assign legal_mask[g] = (GV == PS_EXT) || (!GV[0] && !(GV[2] && GV[3]));
  end

  assign pfx_o   = byte_to_pfx(byte_i);
  assign legal_o = legal_mask[cand_i];

endmodule

// File: rtl/opf_pc.sv
module opf_pc #(
  parameter int          ADDR_W   = 16,
  parameter logic [15:0] RESET_PC = 16'h0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_i,
  output logic [ADDR_W-1:0] pc_o
);

  logic [ADDR_W-1:0] pc_q, pc_d;

  always_comb begin
    pc_d = pc_q;
    if (step_i) pc_d = pc_q + ADDR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= ADDR_W'(RESET_PC);
    else if (step_i) pc_q <= pc_d;
  end

  assign pc_o = pc_q;

endmodule

// File: rtl/opf_ctrl.sv
module opf_ctrl
  import opf_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              next_req,
  input  logic              imm_req,
  input  logic              halt_req,
  input  pfx_set_t          byte_pfx,
  input  logic              cand_legal,
  output pfx_set_t          cand_cls,
  output logic              mem_req,
  output logic              step,
  output logic              op_valid,
  output pfx_set_t          op_class,
  output logic [DATA_W-1:0] op_byte,
  output logic              op_invalid,
  output logic              imm_valid,
  output logic [2*DATA_W-1:0] imm_data,
  output logic              halted
);

  seq_state_t st_q, st_d;
  pfx_set_t   cls_q, cls_d;
  logic [DATA_W-1:0] lo_q, lo_d;

  logic              ov_d, inv_d, iv_d;
  pfx_set_t          ocls_d;
  logic [DATA_W-1:0] obyte_d;
  logic              emit, imm_done;
  logic [2*DATA_W-1:0] idata_d;

  assign mem_req = (st_q == ST_OP1) || (st_q == ST_OP2) || (st_q == ST_OP3) ||
                   (st_q == ST_IMM_LO) || (st_q == ST_IMM_HI);
  assign step    = mem_req && mem_ack;
  assign cand_cls = (st_q == ST_OP1) ? PS_NONE : cls_q;

  always_comb begin
    st_d     = st_q;
    cls_d    = cls_q;
    lo_d     = lo_q;
    emit     = 1'b0;
    imm_done = 1'b0;
    unique case (st_q)
      ST_OP1: if (mem_ack) begin
        if (byte_pfx != PS_NONE) begin
          cls_d = byte_pfx;
          st_d  = ST_OP2;
        end else begin
          emit = 1'b1;
        end
      end
      ST_OP2: if (mem_ack) begin
        if ((byte_pfx != PS_NONE) && can_chain(cls_q)) begin
          cls_d = cls_q | byte_pfx;
          st_d  = ST_OP3;
        end else begin
          emit = 1'b1;
        end
      end
      ST_OP3: if (mem_ack) emit = 1'b1;
      ST_IMM_LO: if (mem_ack) begin
        lo_d = mem_rdata;
        st_d = ST_IMM_HI;
      end
      ST_IMM_HI: if (mem_ack) begin
        imm_done = 1'b1;
        st_d     = ST_IDLE;
      end
      ST_IDLE: begin
        if (halt_req)      st_d = ST_HALT;
        else if (imm_req)  st_d = ST_IMM_LO;
        else if (next_req) begin
          st_d  = ST_OP1;
          cls_d = PS_NONE;
        end
      end
      ST_HALT: st_d = ST_HALT;
      default: st_d = ST_HALT;
    endcase
    if (emit) st_d = ST_IDLE;
  end

  always_comb begin
    ov_d    = emit;
    ocls_d  = emit ? cand_cls : op_class;
    obyte_d = emit ? mem_rdata : op_byte;
    inv_d   = emit && !cand_legal;
    iv_d    = imm_done;
    idata_d = imm_done ? {mem_rdata, lo_q} : imm_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_OP1;
      cls_q      <= PS_NONE;
      lo_q       <= '0;
      op_valid   <= 1'b0;
      op_class   <= PS_NONE;
      op_byte    <= '0;
      op_invalid <= 1'b0;
      imm_valid  <= 1'b0;
      imm_data   <= '0;
    end else begin
      st_q       <= st_d;
      cls_q      <= cls_d;
      lo_q       <= lo_d;
      op_valid   <= ov_d;
      op_class   <= ocls_d;
      op_byte    <= obyte_d;
      op_invalid <= inv_d;
      imm_valid  <= iv_d;
      imm_data   <= idata_d;
    end
  end

  assign halted = (st_q == ST_HALT);

endmodule

// File: rtl/opfetch_seq.sv
module opfetch_seq
  import opf_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter int          DATA_W   = 8,
  parameter logic [15:0] RESET_PC = 16'h0000
) (
  input  logic                clk,
  input  logic                rst_n,
  output logic                mem_req,
  output logic [ADDR_W-1:0]   mem_addr,
  input  logic                mem_ack,
  input  logic [DATA_W-1:0]   mem_rdata,
  input  logic                next_req,
  input  logic                imm_req,
  input  logic                halt_req,
  output logic                op_valid,
  output logic [3:0]          op_class,
  output logic [DATA_W-1:0]   op_byte,
  output logic                op_invalid,
  output logic                imm_valid,
  output logic [2*DATA_W-1:0] imm_data,
  output logic                halted,
  output logic [ADDR_W-1:0]   pc
);

  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  pfx_set_t   byte_pfx, cand_cls, cls_out;
  logic       cand_legal, step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  opf_pfx_dec u_dec (
    .byte_i  (mem_rdata),
    .cand_i  (cand_cls),
    .pfx_o   (byte_pfx),
    .legal_o (cand_legal)
  );

  opf_pc #(.ADDR_W(ADDR_W), .RESET_PC(RESET_PC)) u_pc (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .step_i (step),
    .pc_o   (pc)
  );

  opf_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .mem_ack    (mem_ack),
    .mem_rdata  (mem_rdata),
    .next_req   (next_req),
    .imm_req    (imm_req),
    .halt_req   (halt_req),
    .byte_pfx   (byte_pfx),
    .cand_legal (cand_legal),
    .cand_cls   (cand_cls),
    .mem_req    (mem_req),
    .step       (step),
    .op_valid   (op_valid),
    .op_class   (cls_out),
    .op_byte    (op_byte),
    .op_invalid (op_invalid),
    .imm_valid  (imm_valid),
    .imm_data   (imm_data),
    .halted     (halted)
  );

  assign op_class = cls_out;
  assign mem_addr = pc;

endmodule

// File: rtl/opf_chk.sv
module opf_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [ADDR_W-1:0] pc,
  input logic              op_valid,
  input logic [3:0]        op_class,
  input logic              op_invalid,
  input logic              imm_valid,
  input logic              halted
);

  p_pc_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack) |=> (pc == $past(pc) + ADDR_W'(1)));

  p_pc_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && mem_ack) |=> $stable(pc));

  p_addr_is_pc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_addr == pc);

  p_op_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> !op_valid);

  p_inv_class_r6: assert property (@(posedge clk) disable iff (!rst_n)
    op_invalid |-> (op_valid && !(op_class inside {4'd0, 4'd1, 4'd2, 4'd4,
                                                   4'd6, 4'd8, 4'd10})));

  p_idle_after_op_r9: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |-> !mem_req);

  p_imm_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    imm_valid |=> !imm_valid);

  p_halt_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  p_halt_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !mem_req);

  p_strobe_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_valid && imm_valid));

endmodule

bind opfetch_seq opf_chk #(.ADDR_W(ADDR_W)) u_opf_chk (
  .clk        (clk),
  .rst_n      (rst_int_n),
  .mem_req    (mem_req),
  .mem_ack    (mem_ack),
  .mem_addr   (mem_addr),
  .pc         (pc),
  .op_valid   (op_valid),
  .op_class   (op_class),
  .op_invalid (op_invalid),
  .imm_valid  (imm_valid),
  .halted     (halted)
);

// File: tb/tb_opfetch_seq.sv
module tb_opfetch_seq;

  logic        clk;
  logic        rst_n;
  logic        mem_req;
  logic [15:0] mem_addr;
  logic        mem_ack;
  logic [7:0]  mem_rdata;
  logic        next_req, imm_req, halt_req;
  logic        op_valid;
  logic [3:0]  op_class;
  logic [7:0]  op_byte;
  logic        op_invalid;
  logic        imm_valid;
  logic [15:0] imm_data;
  logic        halted;
  logic [15:0] pc;

  int checks = 0;
  int errors = 0;
  logic [15:0] exp_pc;
  int lat_ctr = 0;
  bit done = 0;

  opfetch_seq dut (
    .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .next_req(next_req),
    .imm_req(imm_req), .halt_req(halt_req), .op_valid(op_valid),
    .op_class(op_class), .op_byte(op_byte), .op_invalid(op_invalid),
    .imm_valid(imm_valid), .imm_data(imm_data), .halted(halted), .pc(pc)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] pbit(input logic [7:0] b);
    case (b)
      8'hED: return 4'd1;
      8'hCB: return 4'd2;
      8'hDD: return 4'd4;
      8'hFD: return 4'd8;
      default: return 4'd0;
    endcase
  endfunction

  function automatic bit legal(input logic [3:0] c);
    return c inside {4'd0, 4'd1, 4'd2, 4'd4, 4'd6, 4'd8, 4'd10};
  endfunction

  // Serve one byte: a few wait cycles, then a one-cycle acknowledge.
  task automatic give(input logic [7:0] b, input string req);
    int lat = lat_ctr % 3;
    lat_ctr++;
    for (int w = 0; w < lat; w++) begin
      chk(mem_req === 1'b1 && mem_addr === exp_pc, "R7 wait", mem_addr, exp_pc);
      @(negedge clk);
    end
    chk(mem_req === 1'b1, {req, " req"}, mem_req, 1);
    chk(mem_addr === exp_pc, "R8 addr", mem_addr, exp_pc);
    mem_ack = 1'b1;
    mem_rdata = b;
    @(negedge clk);
    mem_ack = 1'b0;
    exp_pc++;
  endtask

  task automatic pulse_next();
    next_req = 1'b1;
    @(negedge clk);
    next_req = 1'b0;
  endtask

  // Run one instruction whose bytes are b0, b1, b2 (only as many as needed).
  task automatic run_instr(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2);
    logic [3:0] c;
    logic [7:0] o;
    string r;
    give(b0, "R2");
    if (pbit(b0) == 4'd0) begin
      c = 4'd0; o = b0; r = "R2";
    end else begin
      give(b1, "R3");
      if (pbit(b1) != 4'd0 && (pbit(b0) == 4'd4 || pbit(b0) == 4'd8)) begin
        give(b2, "R5");
        c = pbit(b0) | pbit(b1); o = b2; r = "R5";
      end else begin
        c = pbit(b0); o = b1;
        r = (pbit(b0) == 4'd1 || pbit(b0) == 4'd2) ? "R4" : "R3";
      end
    end
    chk(op_valid === 1'b1, r, op_valid, 1);
    chk(op_class === c, r, op_class, c);
    chk(op_byte === o, r, op_byte, o);
    chk(op_invalid === !legal(c), "R6", op_invalid, !legal(c));
    chk(pc === exp_pc, "R7 count", pc, exp_pc);
    @(negedge clk);
    chk(op_valid === 1'b0, "R2 pulse", op_valid, 0);
    chk(mem_req === 1'b0, "R9 idle", mem_req, 0);
    pulse_next();
  endtask

  initial begin
    mem_ack = 0; mem_rdata = 0; next_req = 0; imm_req = 0; halt_req = 0;
    rst_n = 0;
    exp_pc = 16'h0000;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R1
    chk(pc === 16'h0 && mem_addr === 16'h0, "R1 pc", pc, 0);
    chk(mem_req === 1'b1, "R1 req", mem_req, 1);
    chk(op_valid === 0 && op_invalid === 0 && imm_valid === 0 && halted === 0,
        "R1 outs", {op_valid, op_invalid, imm_valid, halted}, 0);

    // Every first byte, with a plain second byte.
    for (int a = 0; a < 256; a++) run_instr(8'(a), 8'h00, 8'h00);
    // Every escape byte followed by every second byte.
    for (int p = 0; p < 4; p++) begin
      for (int s = 0; s < 256; s++) begin
        logic [7:0] e;
        e = (p == 0) ? 8'hED : (p == 1) ? 8'hCB : (p == 2) ? 8'hDD : 8'hFD;
        run_instr(e, 8'(s), 8'(s) ^ 8'h5A);
      end
    end
    // Third byte that is itself an escape value is the opcode (R5).
    run_instr(8'hDD, 8'hCB, 8'hDD);
    run_instr(8'hFD, 8'hFD, 8'hED);

    // R9: stray acknowledge while idle is ignored.
    give(8'h00, "R2");
    @(negedge clk);
    mem_ack = 1'b1; mem_rdata = 8'hCB;
    @(negedge clk);
    mem_ack = 1'b0;
    chk(pc === exp_pc, "R7 stray ack", pc, exp_pc);
    chk(mem_req === 1'b0 && op_valid === 1'b0, "R9 stray ack", mem_req, 0);

    // R10 and R12: imm wins over next.
    imm_req = 1'b1; next_req = 1'b1;
    @(negedge clk);
    imm_req = 1'b0; next_req = 1'b0;
    give(8'h34, "R10 lo");
    give(8'h12, "R10 hi");
    chk(imm_valid === 1'b1, "R10 strobe", imm_valid, 1);
    chk(imm_data === 16'h1234, "R10 data", imm_data, 16'h1234);
    chk(op_valid === 1'b0, "R12 imm first", op_valid, 0);
    @(negedge clk);
    chk(imm_valid === 1'b0, "R10 pulse", imm_valid, 0);
    chk(mem_req === 1'b0, "R9 after imm", mem_req, 0);
    imm_req = 1'b1;
    @(negedge clk);
    imm_req = 1'b0;
    give(8'hFE, "R10 lo");
    give(8'hCA, "R10 hi");
    chk(imm_data === 16'hCAFE, "R10 data", imm_data, 16'hCAFE);
    pulse_next();
    run_instr(8'h3E, 8'h00, 8'h00);

    // R11 and R12: halt wins over imm and next.
    give(8'h76, "R2");
    @(negedge clk);
    halt_req = 1'b1; imm_req = 1'b1; next_req = 1'b1;
    @(negedge clk);
    halt_req = 1'b0; imm_req = 1'b0; next_req = 1'b0;
    chk(halted === 1'b1, "R12 halt first", halted, 1);
    chk(mem_req === 1'b0, "R11 no req", mem_req, 0);
    mem_ack = 1'b1;
    next_req = 1'b1;
    repeat (4) @(negedge clk);
    mem_ack = 1'b0;
    next_req = 1'b0;
    chk(pc === exp_pc, "R11 pc hold", pc, exp_pc);
    chk(halted === 1'b1 && mem_req === 1'b0, "R11 sticky", halted, 1);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule